// File: doc/BRIEF.md
# Debug Command Sequencer with Bus Access

This block sits between a debug serial receiver and the chip's internal bus. It takes a stream of received bytes, each marked by a one-cycle valid strobe, and recognises four commands: read byte, read word, write byte and write word. Each command is an opcode followed by a 16-bit address, high byte first. A write command then carries one data byte or two data bytes, the high byte first. The block does not require the processor to be halted. Before it touches the bus, it waits for a free (dead) bus cycle. It then owns the bus until the slave reports ready. After the first cycle of an access, it raises a clock-freeze request to the processor. As a result, an access that finishes in one cycle leaves the processor untouched.

There is no handshake with the host. The host waits a fixed budget of target cycles before its next transfer. A read result is latched as soon as the bus returns it. The result is then presented byte by byte on a transmit strobe for the serial layer to shift out. If no dead cycle appears within the wait limit, the access goes ahead anyway, so that the result is ready inside the host's budget, and a timeout flag is raised.

Top module: `dbg_cmd_seq`

## Requirements
- R1: Opcode 0xE0 is read byte, 0xE8 is read word, 0xC0 is write byte and 0xC8 is write word. Any other byte received while an opcode is expected is dropped. It causes no bus request and no transmit strobe, and the next byte is again taken as an opcode.
- R2: After an opcode, the next two strobed bytes form the address, high byte first. For write word, two further bytes give the data, high byte first. For write byte, one further byte gives the data.
- R3: Once all bytes of a command are in, the block samples `bus_idle` each cycle. `bus_req` rises in the cycle after the first cycle in which `bus_idle` is high.
- R4: If `bus_idle` stays low for IDLE_LIMIT (default 128) consecutive waiting cycles, the access is issued anyway and `idle_timeout` goes high. `idle_timeout` stays high until the next recognised opcode is accepted.
- R5: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_addr`, `bus_wdata` and `bus_we` keep their values. `bus_req` falls in the cycle after `bus_ready` is seen high.
- R6: `cpu_freeze` is low in the first cycle of an access. It is high in every further cycle of that access, so the number of freeze cycles equals the number of cycles the access waited on `bus_ready`.
- R7: A read latches `bus_rdata` in the ready cycle. Read word then strobes `tx_valid` in two consecutive cycles, carrying bits 15:8 and then bits 7:0. Read byte strobes once, carrying bits 7:0.
- R8: For a word access, `bus_size` is 1. For a byte access, `bus_size` is 0 and a write carries its data byte in `bus_wdata[7:0]` with the upper bits zero. `bus_we` is 1 only for writes, and a write strobes no `tx_valid`.
- R9: After reset, `tx_valid`, `bus_req`, `cpu_freeze` and `idle_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received command byte |
| rx_valid | input | 1 | One-cycle strobe marking a new rx_byte |
| tx_byte | output | 8 | Read data byte to transmit |
| tx_valid | output | 1 | tx_byte is valid this cycle |
| bus_idle | input | 1 | Bus has a free (dead) cycle |
| bus_req | output | 1 | Bus access request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes this cycle |
| cpu_freeze | output | 1 | Request to stop processor clocks |
| idle_timeout | output | 1 | Last access went ahead without a dead cycle |

## Verification
A wrong sequencer state shows up at the bus within one command. A byte taken in the wrong slot appears as a wrong address or wrong data in the bench's memory. A dropped opcode that is not really dropped shows up as an unexpected bus request within a few cycles. A bad freeze flag changes the count of freeze cycles against the slave latency set by the bench, in the same access. Bad read latching or a wrong byte order appears on the very next transmit strobes. A wrong wait counter moves the timeout flag, which the bench checks both just below and beyond the limit.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam logic [7:0] OPC_RD_B = 8'hE0;
    localparam logic [7:0] OPC_RD_W = 8'hE8;
    localparam logic [7:0] OPC_WR_B = 8'hC0;
    localparam logic [7:0] OPC_WR_W = 8'hC8;

    typedef enum logic [3:0] {
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_DHI,
        ST_DLO,
        ST_WAIT,
        ST_ACC,
        ST_TXH,
        ST_TXL
    } seq_st_e;

    typedef struct packed {
        seq_st_e     st;
        logic        wr;
        logic        wide;
        logic        stall;
        logic        tmo;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdata;
    } seq_s;

endpackage

// File: rtl/dbg_opc_decode.sv
module dbg_opc_decode
    import dbg_seq_pkg::*;
(
    input  logic [7:0] opc,
    output logic       known,
    output logic       is_wr,
    output logic       is_wide
);
    always_comb begin
        known   = 1'b1;
        is_wr   = 1'b0;
        is_wide = 1'b0;
        case (opc)
            OPC_RD_B: ;
            OPC_RD_W: is_wide = 1'b1;
            OPC_WR_B: is_wr = 1'b1;
            OPC_WR_W: begin
                is_wr   = 1'b1;
                is_wide = 1'b1;
            end
            default:  known = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_idle_wait.sv
module dbg_idle_wait #(
    parameter  int LIMIT = 128,
    localparam int CW    = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bus_idle,
    output logic go,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    always_comb begin
        last    = (cnt_q == CW'(LIMIT - 1));
        expired = arm && !bus_idle && last;
        go      = arm && (bus_idle || last);
        cnt_d   = (arm && !go) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the wait never ends while the bus is busy before the limit
    p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !bus_idle && !last) |-> !go);
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_seq_pkg::*;
#(
    parameter int IDLE_LIMIT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    input  logic        bus_idle,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_size,
    output logic [15:0] bus_addr,
    output logic [15:0] bus_wdata,
    input  logic [15:0] bus_rdata,
    input  logic        bus_ready,
    output logic        cpu_freeze,
    output logic        idle_timeout
);
    seq_s q, d;
    logic dec_known, dec_wr, dec_wide;
    logic wait_go, wait_exp;

    dbg_opc_decode u_dec (
        .opc     (rx_byte),
        .known   (dec_known),
        .is_wr   (dec_wr),
        .is_wide (dec_wide)
    );

    dbg_idle_wait #(.LIMIT(IDLE_LIMIT)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (q.st == ST_WAIT),
        .bus_idle (bus_idle),
        .go       (wait_go),
        .expired  (wait_exp)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_OPC: if (rx_valid && dec_known) begin
                d.tmo  = 1'b0;
                d.wr   = dec_wr;
                d.wide = dec_wide;
                d.st   = ST_AHI;
            end
            ST_AHI: if (rx_valid) begin
                d.addr[15:8] = rx_byte;
                d.st         = ST_ALO;
            end
            ST_ALO: if (rx_valid) begin
                d.addr[7:0] = rx_byte;
                d.wdata     = '0;
                if (!q.wr)       d.st = ST_WAIT;
                else if (q.wide) d.st = ST_DHI;
                else             d.st = ST_DLO;
            end
            ST_DHI: if (rx_valid) begin
                d.wdata[15:8] = rx_byte;
                d.st          = ST_DLO;
            end
            ST_DLO: if (rx_valid) begin
                d.wdata[7:0] = rx_byte;
                d.st         = ST_WAIT;
            end
            ST_WAIT: if (wait_go) begin
                d.tmo = wait_exp;
                d.st  = ST_ACC;
            end
            ST_ACC: begin
                if (bus_ready) begin
                    d.stall = 1'b0;
                    if (q.wr) begin
                        d.st = ST_OPC;
                    end else begin
                        d.rdata = bus_rdata;
                        d.st    = q.wide ? ST_TXH : ST_TXL;
                    end
                end else begin
                    d.stall = 1'b1;
                end
            end
            ST_TXH:  d.st = ST_TXL;
            ST_TXL:  d.st = ST_OPC;
            default: d.st = ST_OPC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_OPC;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        tx_valid     = (q.st == ST_TXH) || (q.st == ST_TXL);
        tx_byte      = (q.st == ST_TXH) ? q.rdata[15:8] : q.rdata[7:0];
        bus_req      = (q.st == ST_ACC);
        bus_we       = q.wr;
        bus_size     = q.wide;
        bus_addr     = q.addr;
        bus_wdata    = q.wdata;
        cpu_freeze   = (q.st == ST_ACC) && q.stall;
        idle_timeout = q.tmo;
    end

    // R5: request and its fields held until ready
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)
                                     && $stable(bus_wdata) && $stable(bus_we)));

    // R5: request released after ready
    p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> !bus_req);

    // R6: a one-cycle access never freezes the processor
    p_no_freeze_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !cpu_freeze);

    // R6: every extra access cycle freezes
    p_freeze_on_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> cpu_freeze);

    // R6: no freeze outside an access
    p_freeze_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_freeze |-> bus_req);

    // R3: an access starts only after a dead cycle or an expired wait
    p_issue_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(bus_idle) || idle_timeout));

    // R7: the transmit pair is never split by a bus access
    p_tx_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !bus_req);
endmodule

// File: tb/tb_dbg_cmd_seq.sv
module tb_dbg_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        bus_idle;
    logic        bus_req, bus_we, bus_size;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        cpu_freeze, idle_timeout;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int idle_at = 0;
    int lat = 0;
    int slv_cnt;
    int acc_n = 0, frz_n = 0, tx_n = 0;
    logic [7:0]  tx_last = '0, tx_prev = '0;
    logic [15:0] mem [16];
    logic [15:0] exp_mem [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_cmd_seq #(.IDLE_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .bus_idle(bus_idle),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .cpu_freeze(cpu_freeze), .idle_timeout(idle_timeout)
    );

    assign bus_idle  = (cyc >= idle_at);
    assign bus_ready = bus_req && (slv_cnt == lat);
    assign bus_rdata = bus_size ? mem[bus_addr[3:0]] : {8'h00, mem[bus_addr[3:0]][7:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'(i * 16'h1111) ^ 16'h5A3C;
        end else if (bus_req) begin
            if (bus_ready) begin
                slv_cnt <= 0;
                acc_n   <= acc_n + 1;
                if (bus_we) begin
                    if (bus_size) mem[bus_addr[3:0]] <= bus_wdata;
                    else          mem[bus_addr[3:0]][7:0] <= bus_wdata[7:0];
                end
            end else begin
                slv_cnt <= slv_cnt + 1;
            end
        end else begin
            slv_cnt <= 0;
        end
    end

    always_ff @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tx_valid) begin
            tx_prev <= tx_last;
            tx_last <= tx_byte;
            tx_n    <= tx_n + 1;
        end
        if (cpu_freeze) frz_n <= frz_n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // kind: 0 rd byte, 1 rd word, 2 wr byte, 3 wr word
    task automatic run_cmd(input int kind, input logic [15:0] addr,
                           input logic [15:0] data, input int l, input int dly);
        logic [7:0] opc;
        int a0, f0, t0, guard, idx;
        opc = (kind == 0) ? 8'hE0 : (kind == 1) ? 8'hE8 : (kind == 2) ? 8'hC0 : 8'hC8;
        idx = int'(addr[3:0]);
        lat = l;
        idle_at = cyc + 100000;
        a0 = acc_n; f0 = frz_n; t0 = tx_n;
        send(opc);
        send(addr[15:8]);
        send(addr[7:0]);
        if (kind == 3) send(data[15:8]);
        if (kind >= 2) send(data[7:0]);
        idle_at = cyc + dly;
        guard = 0;
        while (acc_n == a0 && guard < 600) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        chk(acc_n - a0 == 1, "R3 one access per command", acc_n - a0, 1);
        chk(frz_n - f0 == l, "R6 freeze cycles", frz_n - f0, l);
        if (kind == 0) begin
            chk(tx_n - t0 == 1, "R7 byte read strobes", tx_n - t0, 1);
            chk(tx_last == exp_mem[idx][7:0], "R7 byte read data", tx_last, exp_mem[idx][7:0]);
        end else if (kind == 1) begin
            chk(tx_n - t0 == 2, "R7 word read strobes", tx_n - t0, 2);
            chk({tx_prev, tx_last} == exp_mem[idx], "R7 word read order", {tx_prev, tx_last}, exp_mem[idx]);
        end else begin
            if (kind == 3) exp_mem[idx] = data;
            else           exp_mem[idx][7:0] = data[7:0];
            chk(tx_n == t0, "R8 write strobes no tx", tx_n - t0, 0);
            chk(mem[idx] == exp_mem[idx], "R2 R8 written memory", mem[idx], exp_mem[idx]);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = 16'(i * 16'h1111) ^ 16'h5A3C;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!tx_valid && !bus_req && !cpu_freeze && !idle_timeout, "R9 reset outputs",
            {tx_valid, bus_req, cpu_freeze, idle_timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R6 R7 R8 sweep over kind, latency and idle delay
        for (int k = 0; k < 48; k++) begin
            logic [15:0] a, dt;
            a  = {8'(k) ^ 8'h3C, 4'h5, 4'(k)};
            dt = 16'(k * 16'h0B17 + 16'h2301);
            run_cmd(k % 4, a, dt, (k / 4) % 4, k / 16);
            chk(!idle_timeout, "R4 no timeout with early idle", idle_timeout, 0);
        end

        // R1 every unknown opcode is dropped
        for (int op = 0; op < 256; op++) begin
            int a0, t0;
            if (op == 8'hE0 || op == 8'hE8 || op == 8'hC0 || op == 8'hC8) continue;
            a0 = acc_n; t0 = tx_n;
            idle_at = 0;
            send(8'(op));
            repeat (3) @(negedge clk);
            chk(acc_n == a0 && tx_n == t0 && !bus_req, "R1 unknown opcode dropped",
                acc_n - a0 + tx_n - t0, 0);
        end
        // R1 next byte taken as opcode again
        run_cmd(1, 16'h0007, 16'h0, 1, 0);

        // R4 wait just below the limit: no timeout
        run_cmd(1, 16'h0003, 16'h0, 0, LIMIT - 10);
        chk(!idle_timeout, "R4 below limit", idle_timeout, 0);
        // R4 bus never idle: timeout, access still done
        run_cmd(3, 16'h000A, 16'hBEEF, 2, 100000);
        chk(idle_timeout, "R4 timeout flag set", idle_timeout, 1);
        run_cmd(0, 16'h000A, 16'h0, 0, 100000);
        chk(idle_timeout, "R4 timeout flag on read", idle_timeout, 1);
        // R4 flag cleared by next recognised opcode
        run_cmd(1, 16'h000A, 16'h0, 1, 0);
        chk(!idle_timeout, "R4 timeout flag cleared", idle_timeout, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule